// File: doc/BRIEF.md
# Two-Level Management Interrupt and Error Aggregator

This block gathers event pulses from a set of devices into one management interrupt line and one error line for the whole chip. Each device has a row of event sources. Every source has a sticky status bit. Two per-device masks pick which sticky bits raise that device's interrupt line and which raise its error line. The hub then ORs the device lines through its own enable registers. The result is one chip interrupt, which goes to the processor, and one chip error, which goes to the control unit.

The control unit can loop the chip error back into the hub as an interrupt. It does this through a single enable bit, and the looped signal enters the hub on a dedicated slot that has its own enable. Software sets up the masks and enables through a simple register port. It finds the origin of an event by reading which device lines are active, and it acknowledges sources by writing ones to a status register.

Top module: `mgmt_irq_tree`

## Requirements
- R1: After reset every status bit, mask, hub enable and the loop-back enable are zero, both chip outputs are low, and every register reads zero.
- R2: A high bit of `src_evt` (device d, source s at bit d*8+s) sets the matching sticky status bit at the next clock edge. The bit stays set until software clears it.
- R3: A write to a device status register (address 4*d) clears the bits written as one and leaves the others. If a source event and a clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R4: A device's interrupt line is the OR of its status bits ANDed with its interrupt mask (address 4*d+1). Its error line is the OR of its status bits ANDed with its error mask (address 4*d+2).
- R5: `chip_asmi` is the OR of each device interrupt line ANDed with hub interrupt enable bit d (address 24, bits 5:0). It also includes the loop-back slot ANDed with bit 6 of the same register.
- R6: `chip_err` is the OR of each device error line ANDed with hub error enable bit d (address 25, bits 5:0).
- R7: With the loop-back enable (address 26, bit 0) set, the loop-back slot follows `chip_err`. With it clear, the slot is low and `chip_err` has no effect on `chip_asmi`.
- R8: The origin register (address 27, read only) shows the raw device interrupt lines in bits 5:0, the loop-back slot in bit 6 and the raw device error lines in bits 13:8. All other bits read zero.
- R9: Masks and enables read back the value last written, truncated to their width. Unmapped offsets (4*d+3, and addresses 28 to 31) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 48 | Source event pulses, device d source s at bit d*8+s |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data, combinational from rd_addr |
| chip_asmi | output | 1 | Chip management interrupt to the processor |
| chip_err | output | 1 | Chip error to the control unit |

## Verification
The bench aims at a clear and a new event landing on the same status bit in one cycle. A design that let the clear win would lose that event. It also checks the loop-back path with the enable both off and on: a wrong gate would either raise `chip_asmi` from a pure error or fail to raise it when asked. The origin register is compared against raw device lines while hub enables mask the chip outputs, which catches a design that reports only enabled devices or swaps the two halves. Random mask, enable and status traffic catches a wrong mask pairing, such as an error mask driving the interrupt line.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int REG_W = 16;

  localparam logic [1:0] DEV_OFS_STAT = 2'd0;
  localparam logic [1:0] DEV_OFS_AMSK = 2'd1;
  localparam logic [1:0] DEV_OFS_EMSK = 2'd2;
  localparam logic [1:0] HUB_OFS_AEN  = 2'd0;
  localparam logic [1:0] HUB_OFS_EEN  = 2'd1;
  localparam logic [1:0] HUB_OFS_LOOP = 2'd2;
  localparam logic [1:0] HUB_OFS_ORIG = 2'd3;

  localparam int ORIG_ERR_LSB = REG_W / 2;

  // Next value of a sticky row: clear the acknowledged bits, new events win.
  function automatic logic [REG_W-1:0] sticky_next(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] ack,
    input logic [REG_W-1:0] evt
  );
    return (cur & ~ack) | evt;
  endfunction

  // Masked OR reduction shared by both levels of the tree.
  function automatic logic masked_any(
    input logic [REG_W-1:0] vec,
    input logic [REG_W-1:0] msk
  );
    return |(vec & msk);
  endfunction
endpackage

// File: rtl/irq_dev_node.sv
module irq_dev_node
  import irq_tree_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic             wr_stat,
  input  logic             wr_amsk,
  input  logic             wr_emsk,
  input  logic [N_SRC-1:0] wdata,
  output logic [N_SRC-1:0] stat,
  output logic [N_SRC-1:0] amsk,
  output logic [N_SRC-1:0] emsk,
  output logic             dev_asmi,
  output logic             dev_err
);
  logic [N_SRC-1:0] ack;

  assign ack = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      amsk <= '0;
      emsk <= '0;
    end else begin
      stat <= N_SRC'(sticky_next(REG_W'(stat), REG_W'(ack), REG_W'(evt)));
      if (wr_amsk) amsk <= wdata;
      if (wr_emsk) emsk <= wdata;
    end
  end

  assign dev_asmi = masked_any(REG_W'(stat), REG_W'(amsk));
  assign dev_err  = masked_any(REG_W'(stat), REG_W'(emsk));
endmodule

// File: rtl/irq_err_remap.sv
module irq_err_remap (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_sel,
  input  logic wbit,
  input  logic chip_err,
  output logic loop_en,
  output logic loop_asmi
);
  always_ff @(posedge clk) begin
    if (!rst_n)      loop_en <= 1'b0;
    else if (wr_sel) loop_en <= wbit;
  end

  assign loop_asmi = loop_en & chip_err;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_tree_pkg::*;
#(
  parameter int N_DEV = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] dev_asmi,
  input  logic [N_DEV-1:0] dev_err,
  input  logic             loop_asmi,
  input  logic             wr_aen,
  input  logic             wr_een,
  input  logic [REG_W-1:0] wdata,
  output logic [N_DEV:0]   aen,
  output logic [N_DEV-1:0] een,
  output logic [N_DEV:0]   asmi_lines,
  output logic [N_DEV-1:0] err_lines,
  output logic [REG_W-1:0] origin,
  output logic             chip_asmi,
  output logic             chip_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aen <= '0;
      een <= '0;
    end else begin
      if (wr_aen) aen <= wdata[N_DEV:0];
      if (wr_een) een <= wdata[N_DEV-1:0];
    end
  end

  // Slot N_DEV of the interrupt side carries the looped-back error.
  assign asmi_lines = {loop_asmi, dev_asmi};
  assign err_lines  = dev_err;

  assign chip_asmi = masked_any(REG_W'(asmi_lines), REG_W'(aen));
  assign chip_err  = masked_any(REG_W'(err_lines), REG_W'(een));

  always_comb begin
    origin = '0;
    origin[N_DEV:0] = asmi_lines;
    origin[ORIG_ERR_LSB +: N_DEV] = err_lines;
  end
endmodule

// File: rtl/mgmt_irq_tree.sv
module mgmt_irq_tree
  import irq_tree_pkg::*;
#(
  parameter int N_DEV  = 6,   // at most 7 so the origin register fits
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 5    // must cover 4*(N_DEV+1) addresses
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_DEV*N_SRC-1:0] src_evt,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [REG_W-1:0]       wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [REG_W-1:0]       rd_data,
  output logic                   chip_asmi,
  output logic                   chip_err
);
  localparam int BLK_W = ADDR_W - 2;
  localparam int HUB_BLK = N_DEV;

  logic [BLK_W-1:0] wr_blk, rd_blk;
  logic [1:0]       wr_ofs, rd_ofs;

  logic [N_SRC-1:0] stat_a [N_DEV];
  logic [N_SRC-1:0] amsk_a [N_DEV];
  logic [N_SRC-1:0] emsk_a [N_DEV];
  logic [N_DEV-1:0] dev_asmi_v, dev_err_v;
  logic [N_DEV*N_SRC-1:0] sticky_flat;

  logic             hub_sel;
  logic [N_DEV:0]   hub_aen;
  logic [N_DEV-1:0] hub_een;
  logic [N_DEV:0]   asmi_lines;
  logic [N_DEV-1:0] err_lines;
  logic [REG_W-1:0] origin;
  logic             loop_en, loop_asmi;

  assign wr_blk = wr_addr[ADDR_W-1:2];
  assign wr_ofs = wr_addr[1:0];
  assign rd_blk = rd_addr[ADDR_W-1:2];
  assign rd_ofs = rd_addr[1:0];
  assign hub_sel = wr_en && (int'(wr_blk) == HUB_BLK);

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    logic sel;
    assign sel = wr_en && (int'(wr_blk) == d);

    irq_dev_node #(.N_SRC(N_SRC)) u_node (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (src_evt[d*N_SRC +: N_SRC]),
      .wr_stat  (sel && (wr_ofs == DEV_OFS_STAT)),
      .wr_amsk  (sel && (wr_ofs == DEV_OFS_AMSK)),
      .wr_emsk  (sel && (wr_ofs == DEV_OFS_EMSK)),
      .wdata    (wr_data[N_SRC-1:0]),
      .stat     (stat_a[d]),
      .amsk     (amsk_a[d]),
      .emsk     (emsk_a[d]),
      .dev_asmi (dev_asmi_v[d]),
      .dev_err  (dev_err_v[d])
    );

    assign sticky_flat[d*N_SRC +: N_SRC] = stat_a[d];
  end

  irq_hub #(.N_DEV(N_DEV)) u_hub (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_asmi   (dev_asmi_v),
    .dev_err    (dev_err_v),
    .loop_asmi  (loop_asmi),
    .wr_aen     (hub_sel && (wr_ofs == HUB_OFS_AEN)),
    .wr_een     (hub_sel && (wr_ofs == HUB_OFS_EEN)),
    .wdata      (wr_data),
    .aen        (hub_aen),
    .een        (hub_een),
    .asmi_lines (asmi_lines),
    .err_lines  (err_lines),
    .origin     (origin),
    .chip_asmi  (chip_asmi),
    .chip_err   (chip_err)
  );

  irq_err_remap u_remap (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (hub_sel && (wr_ofs == HUB_OFS_LOOP)),
    .wbit      (wr_data[0]),
    .chip_err  (chip_err),
    .loop_en   (loop_en),
    .loop_asmi (loop_asmi)
  );

  always_comb begin
    rd_data = '0;
    for (int d = 0; d < N_DEV; d++) begin
      if (int'(rd_blk) == d) begin
        case (rd_ofs)
          DEV_OFS_STAT: rd_data = REG_W'(stat_a[d]);
          DEV_OFS_AMSK: rd_data = REG_W'(amsk_a[d]);
          DEV_OFS_EMSK: rd_data = REG_W'(emsk_a[d]);
          default:      rd_data = '0;
        endcase
      end
    end
    if (int'(rd_blk) == HUB_BLK) begin
      case (rd_ofs)
        HUB_OFS_AEN:  rd_data = REG_W'(hub_aen);
        HUB_OFS_EEN:  rd_data = REG_W'(hub_een);
        HUB_OFS_LOOP: rd_data = REG_W'(loop_en);
        default:      rd_data = origin;
      endcase
    end
  end
endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk #(
  parameter int N_DEV = 6,
  parameter int N_SRC = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [N_DEV*N_SRC-1:0] src_evt,
  input logic [N_DEV*N_SRC-1:0] sticky_flat,
  input logic [N_DEV-1:0]       dev_asmi_v,
  input logic [N_DEV-1:0]       dev_err_v,
  input logic [N_DEV:0]         hub_aen,
  input logic [N_DEV-1:0]       hub_een,
  input logic                   loop_en,
  input logic                   loop_asmi,
  input logic                   chip_asmi,
  input logic                   chip_err
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((sticky_flat & $past(src_evt)) == $past(src_evt))); // R2

  AST_STICKY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((sticky_flat & $past(sticky_flat)) == $past(sticky_flat))); // R3

  AST_QUIET_DEVICES: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_flat == '0) |-> (dev_asmi_v == '0 && dev_err_v == '0)); // R4

  AST_ASMI_HAS_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    chip_asmi |-> ((|(dev_asmi_v & hub_aen[N_DEV-1:0])) || (loop_asmi && hub_aen[N_DEV]))); // R5

  AST_ERR_HAS_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    chip_err |-> (|(dev_err_v & hub_een))); // R6

  AST_LOOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> !loop_asmi); // R7

  AST_LOOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && chip_err) |-> loop_asmi); // R7
endmodule

bind mgmt_irq_tree irq_tree_chk #(.N_DEV(N_DEV), .N_SRC(N_SRC)) u_irq_tree_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .src_evt     (src_evt),
  .sticky_flat (sticky_flat),
  .dev_asmi_v  (dev_asmi_v),
  .dev_err_v   (dev_err_v),
  .hub_aen     (hub_aen),
  .hub_een     (hub_een),
  .loop_en     (loop_en),
  .loop_asmi   (loop_asmi),
  .chip_asmi   (chip_asmi),
  .chip_err    (chip_err)
);

// File: tb/test_mgmt_irq_tree.sv
`timescale 1ns/1ps
module test_mgmt_irq_tree;
  localparam int ND = 6;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [47:0]   src_evt = '0;
  logic          wr_en = 1'b0;
  logic [4:0]    wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [4:0]    rd_addr = '0;
  logic [15:0]   rd_data;
  logic          chip_asmi, chip_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mgmt_irq_tree i_mgmt_irq_tree (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .chip_asmi(chip_asmi), .chip_err(chip_err)
  );

  // Reference state
  logic [7:0] m_stat [ND];
  logic [7:0] m_am [ND];
  logic [7:0] m_em [ND];
  logic [6:0] m_aen;
  logic [5:0] m_een;
  logic       m_loop;

  function automatic logic [5:0] exp_dev_a();
    logic [5:0] v;
    for (int d = 0; d < ND; d++) v[d] = (m_stat[d] & m_am[d]) != 0;
    return v;
  endfunction

  function automatic logic [5:0] exp_dev_e();
    logic [5:0] v;
    for (int d = 0; d < ND; d++) v[d] = (m_stat[d] & m_em[d]) != 0;
    return v;
  endfunction

  function automatic logic exp_err();
    return (exp_dev_e() & m_een) != 0;
  endfunction

  function automatic logic exp_loopslot();
    return m_loop && exp_err();
  endfunction

  function automatic logic exp_asmi();
    return ((exp_dev_a() & m_aen[5:0]) != 0) || (exp_loopslot() && m_aen[6]);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [4:0] a);
    int blk = int'(a[4:2]);
    logic [1:0] o = a[1:0];
    if (blk < ND) begin
      if (o == 2'd0) return {8'h0, m_stat[blk]};
      if (o == 2'd1) return {8'h0, m_am[blk]};
      if (o == 2'd2) return {8'h0, m_em[blk]};
      return 16'h0;
    end
    if (blk == ND) begin
      if (o == 2'd0) return {9'h0, m_aen};
      if (o == 2'd1) return {10'h0, m_een};
      if (o == 2'd2) return {15'h0, m_loop};
      return {2'b0, exp_dev_e(), 1'b0, exp_loopslot(), exp_dev_a()};
    end
    return 16'h0;
  endfunction

  function automatic string rd_req(input logic [4:0] a);
    if (a[4:2] < 3'd6) return (a[1:0] == 2'd0) ? "R2 R3" : "R9";
    if (a[4:2] == 3'd6) return (a[1:0] == 2'd3) ? "R8" : "R9";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < ND; d++) begin
      m_stat[d] = '0; m_am[d] = '0; m_em[d] = '0;
    end
    m_aen = '0; m_een = '0; m_loop = 1'b0;
  endtask

  // Apply the inputs currently driven for one edge, then check at the falling edge.
  task automatic step(input string ctx);
    @(posedge clk);
    if (rst_n) begin
      for (int d = 0; d < ND; d++) begin
        logic [7:0] ack;
        ack = (wr_en && int'(wr_addr[4:2]) == d && wr_addr[1:0] == 2'd0) ? wr_data[7:0] : 8'h0;
        m_stat[d] = (m_stat[d] & ~ack) | src_evt[d*NS +: NS];
        if (wr_en && int'(wr_addr[4:2]) == d && wr_addr[1:0] == 2'd1) m_am[d] = wr_data[7:0];
        if (wr_en && int'(wr_addr[4:2]) == d && wr_addr[1:0] == 2'd2) m_em[d] = wr_data[7:0];
      end
      if (wr_en && wr_addr == 5'd24) m_aen = wr_data[6:0];
      if (wr_en && wr_addr == 5'd25) m_een = wr_data[5:0];
      if (wr_en && wr_addr == 5'd26) m_loop = wr_data[0];
    end else model_reset();
    @(negedge clk);
    check({"R4 R5 R7 ", ctx}, 16'(chip_asmi), 16'(exp_asmi()));
    check({"R4 R6 ", ctx}, 16'(chip_err), 16'(exp_err()));
    check({rd_req(rd_addr), " ", ctx}, rd_data, exp_rd(rd_addr));
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    step("write");
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    step("reset");
    step("reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: everything reads zero after reset
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a);
      #1;
      check("R1 reset read", rd_data, 16'h0);
    end
    check("R1 reset asmi", 16'(chip_asmi), 16'h0);
    check("R1 reset err", 16'(chip_err), 16'h0);

    // R9: masks and enables read back truncated
    wr(5'd1, 16'hFFA5); rd_addr = 5'd1; #1; check("R9 amask readback", rd_data, 16'h00A5);
    wr(5'd24, 16'hFFFF); rd_addr = 5'd24; #1; check("R9 hub aen width", rd_data, 16'h007F);
    wr(5'd24, 16'h0000);

    // R7: device 0 source 0 as error only, loop slot enabled in hub
    wr(5'd2, 16'h0001);
    wr(5'd1, 16'h0000);
    wr(5'd25, 16'h0001);
    wr(5'd24, 16'h0040);
    src_evt = 48'h1; step("R2 pulse"); src_evt = '0;
    rd_addr = 5'd0; #1; check("R2 sticky set", rd_data, 16'h0001);
    check("R7 loop off err", 16'(chip_err), 16'h1);
    check("R7 loop off asmi", 16'(chip_asmi), 16'h0);
    wr(5'd26, 16'h0001);
    check("R7 loop on asmi", 16'(chip_asmi), 16'h1);
    rd_addr = 5'd27; #1; check("R8 origin", rd_data, 16'h0140);

    // R3: clear and event on the same bit in one cycle, event wins
    src_evt = 48'h3; wr_en = 1'b1; wr_addr = 5'd0; wr_data = 16'h0003;
    step("R3 race"); src_evt = '0; wr_en = 1'b0;
    rd_addr = 5'd0; #1; check("R3 event beats clear", rd_data, 16'h0003);
    wr(5'd0, 16'h0001);
    rd_addr = 5'd0; #1; check("R3 partial clear", rd_data, 16'h0002);
    check("R7 err gone", 16'(chip_err), 16'h0);
    check("R7 loop asmi gone", 16'(chip_asmi), 16'h0);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] r1, r2;
      r1 = {$urandom, $urandom};
      r2 = {$urandom, $urandom};
      src_evt = 48'(r1 & r2 & {$urandom, $urandom});
      wr_en = ($urandom % 4) == 0;
      wr_addr = 5'($urandom);
      wr_data = 16'($urandom);
      if (wr_en && wr_addr[1:0] == 2'd0 && ($urandom % 2) == 0) wr_data = 16'h0000;
      rd_addr = 5'($urandom);
      step("random");
    end
    wr_en = 1'b0;
    src_evt = '0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule